// File: doc/BRIEF.md
# Pipelined Fourth-Order Calibration Polynomial

This block corrects a stream of signed fixed-point samples with a polynomial whose coefficients arrive on input ports. It evaluates the polynomial in nested (Horner) form. Each nesting step gets its own pipeline stage: four rounding multipliers and four saturating adders, all busy at once on different samples. A new sample can enter on every clock. The corrected value leaves a fixed number of cycles later.

Coefficients are plain inputs that may change at any cycle. Nothing is tabulated. Each accepted sample takes a snapshot of the coefficient inputs as it enters, and that snapshot is what its later stages use. Each sample also receives an age tag from a free-running entry counter. The tag travels with the sample, so the output can always be matched to the sample it came from.

Top module: `horner_poly_pipe`

## Requirements
- R1: With Ak on `coef_in[16k+15:16k]` (Q1.14, signed), a valid sample x yields y = ((((A4·x + A3)·x + A2)·x + A1)·x + A0). The steps are applied in exactly that nesting order, and each step uses the rounding and saturation rules of R4 and R5.
- R2: A sample with `in_valid` high at a rising edge appears with `out_valid` high after the 8th rising edge from that one. That is a latency of 8 cycles, one per multiply or add step.
- R3: Samples may be offered on consecutive cycles. Every accepted sample produces exactly one output, and outputs leave in entry order.
- R4: Each product is formed at full width, then has 2^13 added and is arithmetically shifted right by 14 (ties round toward +infinity). The result is then clamped to [-32768, 32767].
- R5: Each sum is clamped to [-32768, 32767] instead of wrapping.
- R6: A sample's result depends only on the x and coefficient values present at its entry edge. Coefficient changes on later cycles do not affect it.
- R7: The age tag of a sample is the value of an 8-bit entry counter at its entry edge. The counter advances by one per accepted sample and wraps from 255 to 0. `out_tag` carries the tag with the result.
- R8: A synchronous active-high reset clears all in-flight valid bits and the entry counter. Samples in flight at reset never appear, and the first sample accepted after reset carries tag 0.
- R9: Cycles with `in_valid` low create no output and do not advance the entry counter, whatever x and the coefficients hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Sample on `in_x` is accepted at this edge |
| in_x | input | 16 | Sample x, signed Q1.14 |
| coef_in | input | 80 | Coefficients; Ak in bits [16k+15:16k], signed Q1.14 |
| out_valid | output | 1 | Result on `out_y` and `out_tag` is valid |
| out_y | output | 16 | Corrected value, signed Q1.14 |
| out_tag | output | 8 | Age tag of the sample that produced `out_y` |

## Verification
The bound checker watches four properties on every cycle. The valid bit must emerge exactly eight edges after entry. Back-to-back results must carry consecutive tags. The first result after reset must carry tag 0, and nothing may emerge in the cycle right after reset. A zero sample must return the A0 it entered with, whatever the other coefficients are. Only the bench's scenarios can show that the arithmetic matches a bit-accurate model and that ties round upward. They also show that saturation engages in both directions and at both multiplier and adder, that coefficients changed mid-stream leave earlier samples untouched, and that tags wrap and match their results after gaps and resets.

// File: rtl/horner_pkg.sv
package horner_pkg;

  // Kind of arithmetic performed by one pipeline step
  typedef enum logic {
    STG_MUL = 1'b0,
    STG_ADD = 1'b1
  } stage_kind_e;

endpackage

// File: rtl/horner_delay.sv
// Plain shift register without reset so that it maps onto shift-register
// primitives; DEPTH must be at least 1.
module horner_delay #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 1
) (
  input  logic              clk,
  input  logic [DATA_W-1:0] d,
  output logic [DATA_W-1:0] q
);

  logic [DEPTH-1:0][DATA_W-1:0] sr;

  always_ff @(posedge clk) begin
    sr[0] <= d;
    for (int j = 1; j < DEPTH; j++) begin
      sr[j] <= sr[j-1];
    end
  end

  assign q = sr[DEPTH-1];

endmodule

// File: rtl/horner_qmul.sv
// Signed Q-format multiply: full product, round half toward +inf, saturate.
module horner_qmul #(
  parameter int DATA_W = 16,
  parameter int FRAC_W = 14
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] y
);

  localparam int PW = 2 * DATA_W + 1;
  localparam logic signed [PW-1:0] HALF  = PW'(1) <<< (FRAC_W - 1);
  localparam logic signed [PW-1:0] MAX_V = PW'((1 << (DATA_W - 1)) - 1);
  localparam logic signed [PW-1:0] MIN_V = ~MAX_V;

  logic signed [PW-1:0] prod;
  logic signed [PW-1:0] rnd;
  logic signed [PW-1:0] shr;

  assign prod = PW'($signed(a)) * PW'($signed(b));
  assign rnd  = prod + HALF;
  assign shr  = rnd >>> FRAC_W;

  always_comb begin
    if (shr > MAX_V) begin
      y = MAX_V[DATA_W-1:0];
    end else if (shr < MIN_V) begin
      y = MIN_V[DATA_W-1:0];
    end else begin
      y = shr[DATA_W-1:0];
    end
  end

endmodule

// File: rtl/horner_stage.sv
// One nesting step: registers acc*opnd (multiply) or acc+opnd (add)
// together with the sample's valid bit and age tag.
module horner_stage
  import horner_pkg::*;
#(
  parameter int          DATA_W = 16,
  parameter int          FRAC_W = 14,
  parameter int          TAG_W  = 8,
  parameter stage_kind_e KIND   = STG_MUL
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              i_vld,
  input  logic [TAG_W-1:0]  i_tag,
  input  logic [DATA_W-1:0] i_acc,
  input  logic [DATA_W-1:0] i_opnd,
  output logic              o_vld,
  output logic [TAG_W-1:0]  o_tag,
  output logic [DATA_W-1:0] o_acc
);

  logic [DATA_W-1:0] res;

  if (KIND == STG_MUL) begin : g_mul
    horner_qmul #(
      .DATA_W(DATA_W),
      .FRAC_W(FRAC_W)
    ) u_qmul (
      .a(i_acc),
      .b(i_opnd),
      .y(res)
    );
  end else begin : g_add
    logic [DATA_W:0] sum;
    assign sum = {i_acc[DATA_W-1], i_acc} + {i_opnd[DATA_W-1], i_opnd};

    always_comb begin
      if (sum[DATA_W] != sum[DATA_W-1]) begin
        res = sum[DATA_W] ? {1'b1, {(DATA_W-1){1'b0}}}
                          : {1'b0, {(DATA_W-1){1'b1}}};
      end else begin
        res = sum[DATA_W-1:0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      o_vld <= 1'b0;
    end else begin
      o_vld <= i_vld;
    end
    o_tag <= i_tag;
    o_acc <= res;
  end

endmodule

// File: rtl/horner_poly_pipe.sv
// Fully pipelined Horner evaluator: 2*ORDER registered steps, alternating
// multiply-by-x and add-coefficient, one new sample per clock.
module horner_poly_pipe
  import horner_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int FRAC_W = 14,
  parameter int TAG_W  = 8,
  parameter int ORDER  = 4
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         in_valid,
  input  logic [DATA_W-1:0]            in_x,
  input  logic [ORDER:0][DATA_W-1:0]   coef_in,
  output logic                         out_valid,
  output logic [DATA_W-1:0]            out_y,
  output logic [TAG_W-1:0]             out_tag
);

  localparam int N_STG = 2 * ORDER;

  logic [TAG_W-1:0]               age_q;
  logic [N_STG:0]                 vld;
  logic [N_STG:0][TAG_W-1:0]      tg;
  logic [N_STG:0][DATA_W-1:0]     acc;
  logic [N_STG:1][DATA_W-1:0]     opnd;
  logic [ORDER-1:0][DATA_W-1:0]   x_tap;   // x delayed by 2*j cycles
  logic [ORDER-1:0][DATA_W-1:0]   c_dly;   // Ak aligned to its add step

  // Entry counter: age tag of the next accepted sample
  always_ff @(posedge clk) begin
    if (rst) begin
      age_q <= '0;
    end else if (in_valid) begin
      age_q <= age_q + 1'b1;
    end
  end

  // Stage 0 bundle: the highest coefficient seeds the accumulator
  assign vld[0]   = in_valid;
  assign tg[0]    = age_q;
  assign acc[0]   = coef_in[ORDER];
  assign x_tap[0] = in_x;

  // x follows its sample two steps per multiply
  for (genvar j = 1; j < ORDER; j++) begin : g_xdly
    horner_delay #(
      .DATA_W(DATA_W),
      .DEPTH (2)
    ) u_xdly (
      .clk(clk),
      .d  (x_tap[j-1]),
      .q  (x_tap[j])
    );
  end

  // Coefficient Ak is consumed by step 2*(ORDER-k); snapshot it on entry
  for (genvar k = 0; k < ORDER; k++) begin : g_cdly
    horner_delay #(
      .DATA_W(DATA_W),
      .DEPTH (2 * (ORDER - k) - 1)
    ) u_cdly (
      .clk(clk),
      .d  (coef_in[k]),
      .q  (c_dly[k])
    );
  end

  for (genvar i = 1; i <= N_STG; i++) begin : g_stage
    localparam stage_kind_e KIND = (i % 2 == 1) ? STG_MUL : STG_ADD;

    if (KIND == STG_MUL) begin : g_xsel
      assign opnd[i] = x_tap[(i-1)/2];
    end else begin : g_csel
      assign opnd[i] = c_dly[ORDER - i/2];
    end

    horner_stage #(
      .DATA_W(DATA_W),
      .FRAC_W(FRAC_W),
      .TAG_W (TAG_W),
      .KIND  (KIND)
    ) u_stage (
      .clk   (clk),
      .rst   (rst),
      .i_vld (vld[i-1]),
      .i_tag (tg[i-1]),
      .i_acc (acc[i-1]),
      .i_opnd(opnd[i]),
      .o_vld (vld[i]),
      .o_tag (tg[i]),
      .o_acc (acc[i])
    );
  end

  assign out_valid = vld[N_STG];
  assign out_y     = acc[N_STG];
  assign out_tag   = tg[N_STG];

endmodule

// File: rtl/horner_poly_chk.sv
module horner_poly_chk #(
  parameter int DATA_W = 16,
  parameter int TAG_W  = 8,
  parameter int ORDER  = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [DATA_W-1:0] in_x,
  input logic [DATA_W-1:0] coef_a0,
  input logic              out_valid,
  input logic [DATA_W-1:0] out_y,
  input logic [TAG_W-1:0]  out_tag
);

  localparam int LAT = 2 * ORDER;

  logic [LAT-1:0]             v_hist;
  logic [LAT-1:0]             z_hist;
  logic [LAT-1:0][DATA_W-1:0] a0_hist;
  logic                       fresh;
  logic                       seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      v_hist <= '0;
      z_hist <= '0;
      fresh  <= 1'b1;
      seen   <= 1'b0;
    end else begin
      v_hist <= {v_hist[LAT-2:0], in_valid};
      z_hist <= {z_hist[LAT-2:0], (in_x == '0)};
      fresh  <= 1'b0;
      if (out_valid) seen <= 1'b1;
    end
    a0_hist <= {a0_hist[LAT-2:0], coef_a0};
  end

  // R2: valid emerges exactly LAT edges after entry
  p_latency_r2: assert property (@(posedge clk) disable iff (rst)
    out_valid == v_hist[LAT-1]);

  // R1: a zero sample returns the A0 it entered with
  p_zero_x_r1: assert property (@(posedge clk) disable iff (rst)
    (v_hist[LAT-1] && z_hist[LAT-1]) |-> out_y == a0_hist[LAT-1]);

  // R7: consecutive results carry consecutive tags
  p_tag_step_r7: assert property (@(posedge clk) disable iff (rst)
    (out_valid && $past(out_valid)) |-> out_tag == TAG_W'($past(out_tag) + 1'b1));

  // R8: nothing emerges right after reset
  p_reset_clear_r8: assert property (@(posedge clk) disable iff (rst)
    fresh |-> !out_valid);

  // R8: first result after reset carries tag 0
  p_first_tag_r8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !seen) |-> out_tag == '0);

endmodule

bind horner_poly_pipe horner_poly_chk #(
  .DATA_W(DATA_W),
  .TAG_W (TAG_W),
  .ORDER (ORDER)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .in_valid (in_valid),
  .in_x     (in_x),
  .coef_a0  (coef_in[0]),
  .out_valid(out_valid),
  .out_y    (out_y),
  .out_tag  (out_tag)
);

// File: tb/test_horner_poly_pipe.sv
module test_horner_poly_pipe;

  localparam int W   = 16;
  localparam int TW  = 8;
  localparam int ORD = 4;
  localparam int LAT = 8;

  typedef struct packed {
    int x; int a4; int a3; int a2; int a1; int a0; int y;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VT [NV] = '{
    '{0,      5000,   -7000,  300, 9,  1000,  1000},   // R1 zero x gives A0
    '{16384,  1000,   1000,   1000, 1000, 1000, 5000}, // R1 x = 1.0
    '{-16384, 1000,   1000,   1000, 1000, 1000, 1000}, // R1 x = -1.0
    '{16384,  30000,  30000,  0,  0,  1000,  32767},   // R5 positive clamp
    '{16384,  -30000, -30000, 0,  0,  -1000, -32768},  // R5 negative clamp
    '{8192,   1,      0,      0,  0,  0,     1},       // R4 +0.5 tie rounds up
    '{8192,   -1,     0,      0,  0,  0,     0},       // R4 -0.5 tie rounds up
    '{-32768, -32768, 0,      0,  0,  0,     -32768},  // R4 product clamp
    '{8192,   0,      0,      0,  5,  0,     3},       // R4 2.5 -> 3
    '{8192,   0,      0,      0,  -5, 0,     -2}       // R4 -2.5 -> -2
  };

  logic                 clk = 1'b0;
  logic                 rst = 1'b1;
  logic                 in_valid = 1'b0;
  logic [W-1:0]         in_x = '0;
  logic [ORD:0][W-1:0]  coef_in = '0;
  logic                 out_valid;
  logic [W-1:0]         out_y;
  logic [TW-1:0]        out_tag;

  horner_poly_pipe i_horner_poly_pipe (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_x     (in_x),
    .coef_in  (coef_in),
    .out_valid(out_valid),
    .out_y    (out_y),
    .out_tag  (out_tag)
  );

  always #4 clk = ~clk;

  int unsigned cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0;
  int n_fail = 0;
  int exp_y [256];
  int unsigned ent [256];
  logic [TW-1:0] sw_tag = '0;
  logic [TW-1:0] want_tag = '0;
  int n_sent = 0;
  int n_recv = 0;
  int last_tag = -1;

  task automatic check(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic int sat16(input longint v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return int'(v);
  endfunction

  function automatic int qm(input int a, input int b);
    longint p;
    p = longint'(a) * longint'(b) + 64'sd8192;
    p = p >>> 14;
    return sat16(p);
  endfunction

  function automatic int qa(input int a, input int b);
    return sat16(longint'(a) + longint'(b));
  endfunction

  function automatic int model(input int x, input int a4, input int a3,
                               input int a2, input int a1, input int a0);
    int r;
    r = qm(a4, x);
    r = qa(r, a3);
    r = qm(r, x);
    r = qa(r, a2);
    r = qm(r, x);
    r = qa(r, a1);
    r = qm(r, x);
    r = qa(r, a0);
    return r;
  endfunction

  function automatic int rnd16();
    return int'($urandom_range(65535)) - 32768;
  endfunction

  // Drive one sample at a falling edge; returns at the next falling edge
  task automatic send(input int x, input int a4, input int a3, input int a2,
                      input int a1, input int a0, input int ev, input bit use_ev);
    in_valid   = 1'b1;
    in_x       = W'(x);
    coef_in[4] = W'(a4);
    coef_in[3] = W'(a3);
    coef_in[2] = W'(a2);
    coef_in[1] = W'(a1);
    coef_in[0] = W'(a0);
    exp_y[sw_tag] = use_ev ? ev : model(x, a4, a3, a2, a1, a0);
    ent[sw_tag]   = cyc;
    sw_tag = sw_tag + 1'b1;
    n_sent++;
    @(negedge clk);
  endtask

  // Idle cycle with garbage on data and coefficients (R6, R9)
  task automatic idle();
    in_valid = 1'b0;
    in_x     = W'(rnd16());
    for (int k = 0; k <= ORD; k++) coef_in[k] = W'(rnd16());
    @(negedge clk);
  endtask

  task automatic drain();
    for (int k = 0; k < LAT + 4; k++) idle();
  endtask

  // Output monitor, sampled at falling edges
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      check(out_tag == want_tag, "R7 tag order", int'(out_tag), int'(want_tag));
      check(int'($signed(out_y)) == exp_y[out_tag], "R1/R4/R5 result value",
            int'($signed(out_y)), exp_y[out_tag]);
      check(int'(cyc - ent[out_tag]) == LAT, "R2 latency",
            int'(cyc - ent[out_tag]), LAT);
      last_tag = int'(out_tag);
      want_tag = want_tag + 1'b1;
      n_recv++;
    end
  end

  task automatic restart();
    rst = 1'b1;
    in_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    sw_tag   = '0;
    want_tag = '0;
    n_sent   = 0;
    n_recv   = 0;
    last_tag = -1;
  endtask

  bit done = 1'b0;

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog R3 actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    restart();

    // R8: reset state
    for (int k = 0; k < 4; k++) begin
      check(out_valid == 1'b0, "R8 reset state valid", int'(out_valid), 0);
      idle();
    end

    // Vector table, back to back (R3)
    for (int v = 0; v < NV; v++) begin
      send(VT[v].x, VT[v].a4, VT[v].a3, VT[v].a2, VT[v].a1, VT[v].a0, VT[v].y, 1'b1);
    end
    drain();
    check(n_recv == n_sent, "R3 one output per sample", n_recv, n_sent);

    // R6: coefficients change right after entry, sample keeps its snapshot
    send(8192, 4000, -3000, 2000, -1000, 500, 0, 1'b0);
    for (int k = 0; k < LAT; k++) idle();
    send(-12000, 16000, 16000, 16000, 16000, 16000, 0, 1'b0);
    send(-12000, -16000, 200, -16000, 300, -16000, 0, 1'b0);
    drain();

    // R9 and R6: random stream with gaps and mid-stream coefficient changes
    begin
      int a [5];
      for (int k = 0; k < 5; k++) a[k] = rnd16();
      for (int n = 0; n < 400; n++) begin
        if ($urandom_range(3) == 0) begin
          for (int k = 0; k < 5; k++) a[k] = rnd16();
        end
        if ($urandom_range(3) == 0) idle();
        else send(rnd16(), a[4], a[3], a[2], a[1], a[0], 0, 1'b0);
      end
    end
    drain();
    check(n_recv == n_sent, "R9 idle cycles add no outputs", n_recv, n_sent);

    // R7: tag wrap with a continuous stream
    for (int n = 0; n < 300; n++) begin
      send(rnd16(), rnd16(), rnd16(), rnd16(), rnd16(), rnd16(), 0, 1'b0);
    end
    drain();
    check(n_recv == n_sent, "R3 continuous stream count", n_recv, n_sent);

    // R8: reset with samples in flight
    for (int n = 0; n < 5; n++) send(1000 * n, 100, 200, 300, 400, 500, 0, 1'b0);
    restart();
    for (int k = 0; k < LAT + 2; k++) begin
      check(out_valid == 1'b0, "R8 in-flight samples dropped", int'(out_valid), 0);
      idle();
    end
    check(n_recv == 0, "R8 no outputs after reset", n_recv, 0);
    send(16384, 0, 0, 0, 0, 77, 77, 1'b1);
    drain();
    check(last_tag == 0, "R8 first tag after reset", last_tag, 0);
    check(n_recv == 1, "R8 single output after reset", n_recv, 1);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule